// File: doc/BRIEF.md
# Write-Through Cache Pair With Posted Write Buffer

This block is the on-chip memory subsystem that sits between a processor pipeline and a single external memory bus. It holds two small direct-mapped caches of one word per line. One serves instruction fetches and is never written by the CPU. The other serves loads and stores. Stores are write-through: each one is placed in a small posted queue and the CPU moves on at once. The queue then drains to memory in the background.

All bus traffic goes through one arbiter. Pending writes always win the bus. After them come data-side misses, and instruction-side misses come last. A data read that misses waits until the queue is empty. This keeps a load from seeing memory older than its own earlier stores. Only one fixed address window is cacheable, and all other reads go straight to the bus every time. A swap input exchanges the roles of the two physical arrays, so the lines filled by fetches become visible to loads, and the other way round. The swap input is expected to change only while both CPU ports are idle.

The CPU handshake is the same on both ports. The CPU raises a request with its address, and with data for a store, and holds them until it sees the stall output low. The access completes on the clock edge where the request is high and the stall is low. Read data is valid during that cycle. The memory bus holds `bus_valid`, address, direction and write data steady until `bus_ready`. The transfer completes on the edge where both are high, and read data is valid while `bus_ready` is high.

Top module: `wtc_mem_sys`

## Requirements
- R1: A cached read that hits completes in the cycle it is presented, with no stall and no bus transaction.
- R2: A read whose address has bits [31:29] not equal to 3'b100 is uncached. Every such read, on either port, performs its own bus read, and no line is filled by it.
- R3: A cached read that misses issues one bus read and stalls until `bus_ready`. It returns the bus data in that cycle and fills the line, so a repeat read hits.
- R4: A store is accepted without stall while the write buffer has a free slot. Buffered stores appear on the bus as single-word writes (`bus_we`=1) in the order they were accepted, each carrying its own address and data.
- R5: While the write buffer holds four entries, a further store stalls until an entry has drained.
- R6: A store invalidates the matching line of the data-role array. A later read of that address fetches from the bus and returns the stored value.
- R7: A data read that misses does not start its bus read until every buffered write has completed on the bus.
- R8: Bus priority is write buffer, then data side, then instruction side. Once a transaction has started, `bus_valid`, `bus_addr` and `bus_we` stay steady until `bus_ready`.
- R9: With `swap`=1, the array that served fetches serves loads and stores, and the reverse. Lines filled before the swap hit on the other port afterwards.
- R10: Each array has 128 lines indexed by address bits [8:2] and tagged by bits [31:9]. Two cached addresses that share an index evict each other.
- R11: After reset, no line is valid, no stall is raised for an idle port, and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| swap | input | 1 | Exchange the roles of the two arrays |
| i_req | input | 1 | Instruction fetch request |
| i_addr | input | 32 | Fetch byte address (word aligned) |
| i_rdata | output | 32 | Fetched word |
| i_stall | output | 1 | Fetch not yet complete |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | 1 = store, 0 = load |
| d_addr | input | 32 | Data byte address (word aligned) |
| d_wdata | input | 32 | Store data |
| d_rdata | output | 32 | Load data |
| d_stall | output | 1 | Data access not yet complete |
| bus_valid | output | 1 | Bus transaction requested |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ready | input | 1 | Memory completes the transaction this cycle |
| bus_rdata | input | 32 | Memory read data |

## Verification
The hardest situation to bring about is three-way bus contention. In that case buffered writes, a data-side miss and an instruction-side miss are all waiting together, and the outcome depends on both the priority order and the rule that loads wait for the buffer to drain. The bench slows the memory model to several cycles per transfer and posts three stores back to back. While the first write is still in flight, it raises a load miss and a fetch miss in the same cycle. It then checks the logged bus order: three writes, then the load, then the fetch. Filling the buffer to its limit uses the same slowed memory, so the fifth store is shown to stall.

// File: rtl/wtc_pkg.sv
// Package: shared types and helpers for the write-through cache pair.
// Assumes 32-bit byte addresses with word-aligned accesses.
package wtc_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    // Top three address bits that mark the cacheable window
    localparam logic [2:0] CACHE_WIN = 3'b100;

    typedef enum logic [1:0] {
        OWN_WB   = 2'd0,
        OWN_D    = 2'd1,
        OWN_I    = 2'd2,
        OWN_NONE = 2'd3
    } bus_own_e;

    // True when the address lies in the cacheable window
    function automatic logic is_cached(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 3] == CACHE_WIN;
    endfunction

endpackage

// File: rtl/wtc_array.sv
// Module: one direct-mapped array of one-word lines with valid bits and tags.
// Lookup is combinational on addr; a fill writes the line at addr, an
// invalidate clears its valid bit. Fill and invalidate never coincide.
module wtc_array
    import wtc_pkg::*;
#(
    parameter int LINES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [DATA_W-1:0] rdata,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_en
);
    localparam int IW = $clog2(LINES);
    localparam int TW = ADDR_W - IW - 2;

    logic [LINES-1:0]  valid_q;
    logic [TW-1:0]     tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    logic [IW-1:0] idx;
    logic [TW-1:0] tag;

    // Split the address into line index and tag
    assign idx = addr[IW+1:2];
    assign tag = addr[ADDR_W-1:IW+2];

    // Combinational lookup
    assign hit   = valid_q[idx] && (tag_q[idx] == tag);
    assign rdata = data_q[idx];

    // Valid bits: cleared by reset or invalidate, set by fill
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (fill_en)
            valid_q[idx] <= 1'b1;
        else if (inv_en)
            valid_q[idx] <= 1'b0;
    end

    // Tag and data storage, written on fill only
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= tag;
            data_q[idx] <= fill_data;
        end
    end

endmodule

// File: rtl/wtc_wbuf.sv
// Module: posted write queue (FIFO) of address/data pairs.
// Assumes DEPTH is a power of two; push is never asserted while full.
module wtc_wbuf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [ADDR_W-1:0]          head_addr,
    output logic [DATA_W-1:0]          head_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;

    assign count     = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/wtc_arb.sv
// Module: fixed-priority bus arbiter with hold.
// Priority is write buffer, data side, instruction side. Once a grant is
// on the bus without ready, it is held until ready. Requesters keep their
// request asserted until served.
module wtc_arb
    import wtc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_wb,
    input  logic     req_d,
    input  logic     req_i,
    input  logic     bus_ready,
    output bus_own_e gnt
);
    logic     busy_q;
    bus_own_e own_q;

    // Choose owner: held owner, else highest-priority request
    always_comb begin
        if (busy_q)      gnt = own_q;
        else if (req_wb) gnt = OWN_WB;
        else if (req_d)  gnt = OWN_D;
        else if (req_i)  gnt = OWN_I;
        else             gnt = OWN_NONE;
    end

    // Remember an owner whose transfer is still waiting for ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            own_q  <= OWN_NONE;
        end else begin
            busy_q <= (gnt != OWN_NONE) && !bus_ready;
            own_q  <= gnt;
        end
    end

endmodule

// File: rtl/wtc_mem_sys.sv
// Module: top of the write-through cache pair with a posted write buffer
// and one arbitrated memory bus. Two physical arrays; swap picks which
// one serves the data port. Assumes swap changes only while both ports
// are idle, and that requesters hold address/data until stall is low.
module wtc_mem_sys
    import wtc_pkg::*;
#(
    parameter int CACHE_BYTES = 512,
    parameter int WB_DEPTH    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        swap,
    input  logic        i_req,
    input  logic [31:0] i_addr,
    output logic [31:0] i_rdata,
    output logic        i_stall,
    input  logic        d_req,
    input  logic        d_we,
    input  logic [31:0] d_addr,
    input  logic [31:0] d_wdata,
    output logic [31:0] d_rdata,
    output logic        d_stall,
    output logic        bus_valid,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ready,
    input  logic [31:0] bus_rdata
);
    localparam int LINES = CACHE_BYTES / (DATA_W / 8);
    localparam int CW    = $clog2(WB_DEPTH + 1);

    logic              arr_hit   [2];
    logic [DATA_W-1:0] arr_rdata [2];
    logic              d_sel, i_sel;
    logic              d_cached, i_cached, d_hit, i_hit;
    logic              d_rd, d_push, d_done, i_done, d_fill, i_fill;
    logic              wb_full, wb_empty, wb_pop;
    logic [CW-1:0]     wb_count;
    logic [31:0]       wb_head_addr, wb_head_data;
    bus_own_e          gnt;

    // Array role selection: index 1 is the data array unless swapped
    assign d_sel = ~swap;
    assign i_sel = swap;

    // Two physical arrays; each takes the port of its current role
    for (genvar k = 0; k < 2; k++) begin : g_arr
        logic role_d;
        assign role_d = swap ^ (k == 1);
        wtc_array #(.LINES(LINES)) u_arr (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr      (role_d ? d_addr : i_addr),
            .hit       (arr_hit[k]),
            .rdata     (arr_rdata[k]),
            .fill_en   (role_d ? d_fill : i_fill),
            .fill_data (bus_rdata),
            .inv_en    (role_d & d_push)
        );
    end

    // Data-side lookup, store acceptance and completion
    assign d_cached = is_cached(d_addr);
    assign d_hit    = d_cached & arr_hit[d_sel];
    assign d_rd     = d_req & ~d_we;
    assign d_push   = d_req & d_we & ~wb_full;
    assign d_done   = (gnt == OWN_D) & bus_ready;
    assign d_fill   = d_done & d_cached;
    assign d_stall  = d_req & (d_we ? wb_full : ~(d_hit | d_done));
    assign d_rdata  = d_hit ? arr_rdata[d_sel] : bus_rdata;

    // Instruction-side lookup and completion
    assign i_cached = is_cached(i_addr);
    assign i_hit    = i_cached & arr_hit[i_sel];
    assign i_done   = (gnt == OWN_I) & bus_ready;
    assign i_fill   = i_done & i_cached;
    assign i_stall  = i_req & ~(i_hit | i_done);
    assign i_rdata  = i_hit ? arr_rdata[i_sel] : bus_rdata;

    assign wb_pop = (gnt == OWN_WB) & bus_ready;

    wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (d_push),
        .push_addr (d_addr),
        .push_data (d_wdata),
        .pop       (wb_pop),
        .head_addr (wb_head_addr),
        .head_data (wb_head_data),
        .count     (wb_count),
        .full      (wb_full),
        .empty     (wb_empty)
    );

    wtc_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wb    (~wb_empty),
        .req_d     (d_rd & ~d_hit & wb_empty),
        .req_i     (i_req & ~i_hit),
        .bus_ready (bus_ready),
        .gnt       (gnt)
    );

    // Bus drive from the current owner
    always_comb begin
        bus_valid = (gnt != OWN_NONE);
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (gnt)
            OWN_WB: begin
                bus_we    = 1'b1;
                bus_addr  = wb_head_addr;
                bus_wdata = wb_head_data;
            end
            OWN_D:   bus_addr = d_addr;
            OWN_I:   bus_addr = i_addr;
            default: bus_addr = '0;
        endcase
    end

endmodule

// File: rtl/wtc_mem_sys_chk.sv
// Module: assertion checker for wtc_mem_sys, attached by bind below.
// Observes ports and the write-buffer occupancy.
module wtc_mem_sys_chk #(
    parameter int CW = 3,
    parameter int WB_DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_ready,
    input logic          bus_we,
    input logic [31:0]   bus_addr,
    input logic          d_req,
    input logic          d_we,
    input logic [31:0]   d_addr,
    input logic          d_stall,
    input logic [CW-1:0] wb_count
);
    // R8: a started transfer holds its address and direction until ready
    p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

    // R7: a read transfer only starts on an empty write buffer
    p_read_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) && !bus_we |-> wb_count == '0);

    // R4: bus writes only come from buffered stores
    p_write_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we |-> wb_count != '0);

    // R5: a store to a full buffer stalls
    p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_req && d_we && (wb_count == CW'(WB_DEPTH)) |-> d_stall);

    // R2: an uncached load completes only with a bus read
    p_uncached_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        d_req && !d_we && !d_stall && (d_addr[31:29] != 3'b100) |-> bus_ready && bus_valid && !bus_we);

endmodule

bind wtc_mem_sys wtc_mem_sys_chk #(.CW(CW), .WB_DEPTH(WB_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .d_req     (d_req),
    .d_we      (d_we),
    .d_addr    (d_addr),
    .d_stall   (d_stall),
    .wb_count  (wb_count)
);

// File: tb/wtc_mem_sys_tb.sv
`timescale 1ns/1ps
// Bench: sweeps all data lines, instruction lines, window edges, buffer
// fill, store/load ordering, three-way contention and swap. The memory
// model has a settable latency and logs every bus transfer.
module wtc_mem_sys_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap = 1'b0;
    logic        i_req = 1'b0, d_req = 1'b0, d_we = 1'b0;
    logic [31:0] i_addr = '0, d_addr = '0, d_wdata = '0;
    logic [31:0] i_rdata, d_rdata;
    logic        i_stall, d_stall;
    logic        bus_valid, bus_we, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int n_checks = 0, n_fail = 0;
    int lat = 1;
    int wcnt = 0;
    int n_log = 0, n_rd = 0, n_wr = 0;
    logic        lg_we   [0:1023];
    logic [31:0] lg_addr [0:1023];
    logic [31:0] lg_data [0:1023];
    logic [31:0] mem     [0:1023];

    always #2.5 clk = ~clk;

    wtc_mem_sys u_dut (.*);

    // Memory word for an address before any store
    function automatic logic [31:0] init_val(input logic [31:0] a);
        return 32'hC0DE_0000 ^ {20'd0, a[31], a[10:2], 2'b01};
    endfunction

    function automatic int midx(input logic [31:0] a);
        return int'({a[31], a[10:2]});
    endfunction

    initial for (int j = 0; j < 1024; j++) mem[j] = init_val({j[9], 20'd0, j[8:0], 2'b00});

    // Memory model: ready after lat wait cycles, logs each transfer
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
            wcnt      <= 0;
        end else if (bus_ready) begin
            bus_ready <= 1'b0;
            wcnt      <= 0;
            lg_we[n_log]   <= bus_we;
            lg_addr[n_log] <= bus_addr;
            lg_data[n_log] <= bus_we ? bus_wdata : bus_rdata;
            n_log <= n_log + 1;
            if (bus_we) begin
                mem[midx(bus_addr)] <= bus_wdata;
                n_wr <= n_wr + 1;
            end else
                n_rd <= n_rd + 1;
        end else if (bus_valid) begin
            if (wcnt >= lat) begin
                bus_ready <= 1'b1;
                bus_rdata <= mem[midx(bus_addr)];
            end else
                wcnt <= wcnt + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic d_read(input logic [31:0] a, output logic [31:0] v, output int cyc);
        @(negedge clk);
        d_req = 1'b1; d_we = 1'b0; d_addr = a; cyc = 0;
        #1;
        while (d_stall) begin @(negedge clk); cyc++; #1; end
        v = d_rdata;
        @(posedge clk); #1;
        d_req = 1'b0;
    endtask

    task automatic d_write(input logic [31:0] a, input logic [31:0] w, output int cyc);
        @(negedge clk);
        d_req = 1'b1; d_we = 1'b1; d_addr = a; d_wdata = w; cyc = 0;
        #1;
        while (d_stall) begin @(negedge clk); cyc++; #1; end
        @(posedge clk); #1;
        d_req = 1'b0; d_we = 1'b0;
    endtask

    task automatic i_fetch(input logic [31:0] a, output logic [31:0] v, output int cyc);
        @(negedge clk);
        i_req = 1'b1; i_addr = a; cyc = 0;
        #1;
        while (i_stall) begin @(negedge clk); cyc++; #1; end
        v = i_rdata;
        @(posedge clk); #1;
        i_req = 1'b0;
    endtask

    task automatic wait_writes(input int target);
        while (n_wr < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int c, c2, nb, n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: idle after reset
        check("R11 bus_valid", 32'(bus_valid), 0);
        check("R11 d_stall", 32'(d_stall), 0);
        check("R11 i_stall", 32'(i_stall), 0);

        // R3 / R11: every data line misses first and returns memory data
        lat = 1;
        for (int k = 0; k < 128; k++) begin
            d_read(32'h8000_0000 + 32'(k*4), v, c);
            check("R3 miss data", v, init_val(32'h8000_0000 + 32'(k*4)));
            check("R3 miss stalls", 32'(c > 0), 1);
        end
        // R1: second pass hits with no stall and no bus read
        nb = n_rd;
        for (int k = 0; k < 128; k++) begin
            d_read(32'h8000_0000 + 32'(k*4), v, c);
            check("R1 hit data", v, init_val(32'h8000_0000 + 32'(k*4)));
            check("R1 hit no stall", 32'(c), 0);
        end
        check("R1 no bus reads", 32'(n_rd - nb), 0);

        // R10: index aliasing evicts
        d_read(32'h8000_0200, v, c);
        check("R10 alias miss", 32'(c > 0), 1);
        nb = n_rd;
        d_read(32'h8000_0000, v, c);
        check("R10 evicted refetch", 32'(n_rd - nb), 1);
        check("R10 data", v, init_val(32'h8000_0000));

        // R3 / R1 on the instruction port
        for (int k = 0; k < 16; k++) begin
            i_fetch(32'h8000_0400 + 32'(k*4), v, c);
            check("R3 fetch miss", 32'(c > 0), 1);
            check("R3 fetch data", v, init_val(32'h8000_0400 + 32'(k*4)));
        end
        nb = n_rd;
        for (int k = 0; k < 16; k++) begin
            i_fetch(32'h8000_0400 + 32'(k*4), v, c);
            check("R1 fetch hit", 32'(c), 0);
        end
        check("R1 fetch no bus", 32'(n_rd - nb), 0);

        // R2: uncached reads and window edges
        nb = n_rd;
        d_read(32'h0000_0010, v, c);  d_read(32'h0000_0010, v2, c2);
        check("R2 uncached bus count", 32'(n_rd - nb), 2);
        check("R2 uncached data", v2, init_val(32'h0000_0010));
        nb = n_rd;
        i_fetch(32'h0000_0020, v, c); i_fetch(32'h0000_0020, v2, c2);
        check("R2 fetch uncached count", 32'(n_rd - nb), 2);
        nb = n_rd;
        d_read(32'hA000_0000, v, c);  d_read(32'hA000_0000, v2, c2);
        check("R2 above window", 32'(n_rd - nb), 2);
        nb = n_rd;
        d_read(32'h7FFF_FFFC, v, c);  d_read(32'h7FFF_FFFC, v2, c2);
        check("R2 below window", 32'(n_rd - nb), 2);
        d_read(32'h9FFF_FFFC, v, c);  d_read(32'h9FFF_FFFC, v2, c2);
        check("R3 top of window cached", 32'(c2), 0);
        check("R3 top of window data", v2, init_val(32'h9FFF_FFFC));

        // R4 / R5: fill the buffer with a slow memory
        lat = 8;
        n0 = n_log;
        nb = n_wr;
        for (int k = 0; k < 4; k++) begin
            d_write(32'h8000_0000 + 32'(k*4), 32'hD000_0000 + 32'(k), c);
            check("R4 store no stall", 32'(c), 0);
        end
        d_write(32'h8000_0010, 32'hD000_0004, c);
        check("R5 full stalls", 32'(c > 0), 1);
        wait_writes(nb + 5);
        for (int k = 0; k < 5; k++) begin
            check("R4 order we", 32'(lg_we[n0+k]), 1);
            check("R4 order addr", lg_addr[n0+k], 32'h8000_0000 + 32'(k*4));
            check("R4 order data", lg_data[n0+k], 32'hD000_0000 + 32'(k));
        end

        // R6 / R7: store then load of a cached line
        lat = 2;
        d_read(32'h8000_0100, v, c);
        d_write(32'h8000_0100, 32'hBEEF_0001, c);
        d_read(32'h8000_0100, v, c);
        check("R6 new value", v, 32'hBEEF_0001);
        check("R6 refetch stalls", 32'(c > 0), 1);
        check("R7 write before read", 32'(lg_we[n_log-2]), 1);
        check("R7 read last", 32'(lg_we[n_log-1]), 0);
        d_read(32'h8000_0100, v, c);
        check("R6 then hits", 32'(c), 0);

        // R8: three writes, a data miss and a fetch miss contend
        lat = 4;
        n0 = n_log;
        d_write(32'h0000_0040, 32'hE000_0000, c);
        d_write(32'h0000_0044, 32'hE000_0001, c);
        d_write(32'h0000_0048, 32'hE000_0002, c);
        fork
            d_read(32'h8000_0340, v, c);
            i_fetch(32'h8000_0640, v2, c2);
        join
        repeat (2) @(negedge clk);
        check("R8 count", 32'(n_log - n0), 5);
        check("R8 w0", {lg_we[n0],   lg_addr[n0][30:0]},   {1'b1, 31'h40});
        check("R8 w1", {lg_we[n0+1], lg_addr[n0+1][30:0]}, {1'b1, 31'h44});
        check("R8 w2", {lg_we[n0+2], lg_addr[n0+2][30:0]}, {1'b1, 31'h48});
        check("R8 data read 4th", lg_addr[n0+3], 32'h8000_0340);
        check("R8 fetch read 5th", lg_addr[n0+4], 32'h8000_0640);
        check("R8 data value", v, init_val(32'h8000_0340));
        check("R8 fetch value", v2, init_val(32'h8000_0640));

        // R9: swap array roles
        lat = 1;
        i_fetch(32'h8000_0700, v, c);
        @(negedge clk); swap = 1'b1;
        nb = n_rd;
        d_read(32'h8000_0700, v, c);
        check("R9 load hits fetched line", 32'(c), 0);
        check("R9 load value", v, init_val(32'h8000_0700));
        i_fetch(32'h8000_0100, v, c);
        check("R9 fetch hits data line", 32'(c), 0);
        check("R9 fetch value", v, 32'hBEEF_0001);
        check("R9 no bus", 32'(n_rd - nb), 0);
        @(negedge clk); swap = 1'b0;
        d_read(32'h8000_0100, v, c);
        check("R9 swap back", v, 32'hBEEF_0001);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule